// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Serial Peripheral Override

This block is one 8-bit general-purpose I/O port. Software sees four byte-wide locations on a small register bus: an output data latch, a view of the pins as inputs only, a direction mask and a reduced-drive mask. For each pin the block works out the pad's output enable, output value and drive strength. It also brings the pad inputs back through a two-flop synchronizer so they can be read.

Three serial peripheral channels can take a pin away from the register settings:
- An SPI block owns the upper four pins and supplies their direction and data.
- A serial transmit channel owns pin 1 and always drives it as an output.
- A serial receive channel owns pin 0 and always leaves it as an input.

When a channel is switched off, its pin goes back to the direction register. If the pin map is changed so that owners overlap, the fixed priority is SPI, then transmit, then receive, then the register.

Top module: `pinmux_port`

## Requirements
- R1: While reset is asserted (rstN low), the data, direction and reduced-drive registers are all zero. With no peripheral enabled, padOe and padReduced are then zero.
- R2: With no peripheral override, a direction bit of 1 sets padOe for that pin and drives padOut from the data register bit. A direction bit of 0 clears padOe.
- R3: The direction register (offset 2) and the reduced-drive register (offset 3) can be written at any time and read back unchanged.
- R4: While spiEn is high, pins 4..7 take padOe from spiOe[pin-4] and padOut from spiOut[pin-4]. The direction and data register bits of those pins are ignored.
- R5: While sciTxEn is high, pin 1 has padOe=1 and padOut=sciTxOut, whatever the registers hold.
- R6: While sciRxEn is high, pin 0 has padOe=0, whatever the direction bit is.
- R7: When a peripheral enable drops, the affected pins return to the direction and data register bits.
- R8: A reading at offset 1 returns padIn as it was two clock edges earlier. A change on padIn is not visible after only one edge.
- R9: A reading at offset 0 returns, bit by bit, the data register bit for pins whose padOe is 1 and the synchronized pad input for pins whose padOe is 0.
- R10: A write to offset 1 changes no register. The data, direction and drive values read back afterwards are unchanged.
- R11: padReduced is the reduced-drive bit (1 = reduced strength) for pins whose padOe is 1, whoever drives the pin. It is 0 for pins that are inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe, sampled on the rising edge |
| busAddr | input | 2 | Register offset: 0 data, 1 input view, 2 direction, 3 reduced drive |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data for busAddr |
| spiEn | input | 1 | SPI owns pins 4..7 |
| spiOe | input | 4 | SPI output enables for pins 4..7 |
| spiOut | input | 4 | SPI output values for pins 4..7 |
| sciTxEn | input | 1 | Serial transmit owns pin 1 |
| sciTxOut | input | 1 | Serial transmit output value |
| sciRxEn | input | 1 | Serial receive owns pin 0 |
| padIn | input | 8 | Raw pad input levels |
| padOut | output | 8 | Pad output values |
| padOe | output | 8 | Pad output enables |
| padReduced | output | 8 | Pad reduced-drive selects |

## Verification
The hardest state to reach is one where every override is active at the same time. In that state, each owner has register settings that would say the opposite if the owner were ignored. One table row enables SPI, transmit and receive together, with an SPI enable pattern that mixes 1s and 0s and with register bits that oppose each owner. A following row turns every enable off and confirms that the register bits take the pins back. The synchronizer latency is checked by changing padIn between clock edges and reading the input view after one edge and again after two.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  // register offsets on the small bus
  localparam logic [1:0] OFF_DATA  = 2'd0;
  localparam logic [1:0] OFF_INPUT = 2'd1;
  localparam logic [1:0] OFF_DIR   = 2'd2;
  localparam logic [1:0] OFF_DRIVE = 2'd3;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_INPUT = 2'd1,
    SEL_DIR   = 2'd2,
    SEL_DRIVE = 2'd3
  } rd_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrDrive;
    rd_sel_e rdSel;
  } port_ctl_t;
endpackage

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
  import pinmux_pkg::*;
(
  input  logic       busWe,
  input  logic [1:0] busAddr,
  output port_ctl_t  ctl
);
  always_comb begin
    ctl.wrData  = busWe && (busAddr == OFF_DATA);
    ctl.wrDir   = busWe && (busAddr == OFF_DIR);
    ctl.wrDrive = busWe && (busAddr == OFF_DRIVE);
    // a write at OFF_INPUT raises no strobe and so changes nothing
    unique case (busAddr)
      OFF_DATA:  ctl.rdSel = SEL_DATA;
      OFF_INPUT: ctl.rdSel = SEL_INPUT;
      OFF_DIR:   ctl.rdSel = SEL_DIR;
      default:   ctl.rdSel = SEL_DRIVE;
    endcase
  end
endmodule

// File: rtl/pinmux_dpath.sv
module pinmux_dpath
  import pinmux_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RX_PIN      = 0,
  parameter int TX_PIN      = 1,
  parameter int SPI_LO      = 4,
  parameter int SPI_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  port_ctl_t        ctl,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic             spiEn,
  input  logic [SPI_W-1:0] spiOe,
  input  logic [SPI_W-1:0] spiOut,
  input  logic             sciTxEn,
  input  logic             sciTxOut,
  input  logic             sciRxEn,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padReduced
);
  localparam int SPI_HI = SPI_LO + SPI_W - 1;

  logic [WIDTH-1:0] dataQ, dirQ, driveQ;
  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ  <= '0;
      dirQ   <= '0;
      driveQ <= '0;
    end else begin
      if (ctl.wrData)  dataQ  <= busWdata;
      if (ctl.wrDir)   dirQ   <= busWdata;
      if (ctl.wrDrive) driveQ <= busWdata;
    end
  end

  // pad input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign pinSync = syncQ[SYNC_STAGES-1];

  // per-pin owner resolution: SPI > TX > RX > register
  for (genvar p = 0; p < WIDTH; p++) begin : g_pin
    logic spiHit, spiOeBit, spiOutBit;
    logic txHit, rxHit;

    if (p >= SPI_LO && p <= SPI_HI) begin : g_spi
      assign spiHit    = spiEn;
      assign spiOeBit  = spiOe[p-SPI_LO];
      assign spiOutBit = spiOut[p-SPI_LO];
    end else begin : g_nospi
      assign spiHit    = 1'b0;
      assign spiOeBit  = 1'b0;
      assign spiOutBit = 1'b0;
    end

    assign txHit = (p == TX_PIN) && sciTxEn;
    assign rxHit = (p == RX_PIN) && sciRxEn;

    always_comb begin
      if (spiHit) begin
        padOe[p]  = spiOeBit;
        padOut[p] = spiOutBit;
      end else if (txHit) begin
        padOe[p]  = 1'b1;
        padOut[p] = sciTxOut;
      end else if (rxHit) begin
        padOe[p]  = 1'b0;
        padOut[p] = dataQ[p];
      end else begin
        padOe[p]  = dirQ[p];
        padOut[p] = dataQ[p];
      end
    end
  end

  assign padReduced = driveQ & padOe;

  always_comb begin
    unique case (ctl.rdSel)
      SEL_DATA:  busRdata = (dataQ & padOe) | (pinSync & ~padOe);
      SEL_INPUT: busRdata = pinSync;
      SEL_DIR:   busRdata = dirQ;
      default:   busRdata = driveQ;
    endcase
  end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pinmux_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RX_PIN      = 0,
  parameter int TX_PIN      = 1,
  parameter int SPI_LO      = 4,
  parameter int SPI_W       = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWe,
  input  logic [1:0]       busAddr,
  input  logic [WIDTH-1:0] busWdata,
  output logic [WIDTH-1:0] busRdata,
  input  logic             spiEn,
  input  logic [SPI_W-1:0] spiOe,
  input  logic [SPI_W-1:0] spiOut,
  input  logic             sciTxEn,
  input  logic             sciTxOut,
  input  logic             sciRxEn,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padReduced
);
  port_ctl_t ctl;

  pinmux_ctrl ctrl_i (
    .busWe   (busWe),
    .busAddr (busAddr),
    .ctl     (ctl)
  );

  pinmux_dpath #(
    .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .RX_PIN(RX_PIN),
    .TX_PIN(TX_PIN), .SPI_LO(SPI_LO), .SPI_W(SPI_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .spiEn      (spiEn),
    .spiOe      (spiOe),
    .spiOut     (spiOut),
    .sciTxEn    (sciTxEn),
    .sciTxOut   (sciTxOut),
    .sciRxEn    (sciRxEn),
    .padIn      (padIn),
    .padOut     (padOut),
    .padOe      (padOe),
    .padReduced (padReduced)
  );
endmodule

// File: rtl/pinmux_port_chk.sv
module pinmux_port_chk #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RX_PIN      = 0,
  parameter int TX_PIN      = 1,
  parameter int SPI_LO      = 4,
  parameter int SPI_W       = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       busAddr,
  input logic [WIDTH-1:0] busRdata,
  input logic             spiEn,
  input logic [SPI_W-1:0] spiOe,
  input logic [SPI_W-1:0] spiOut,
  input logic             sciTxEn,
  input logic             sciTxOut,
  input logic             sciRxEn,
  input logic [WIDTH-1:0] padIn,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] padReduced
);
  logic [1:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 2'd3) upCnt <= upCnt + 2'd1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    (!rstN && !spiEn && !sciTxEn) |-> (padOe == '0 && padReduced == '0));

  assert_spi_owns_R4: assert property (@(posedge clk) disable iff (!rstN)
    spiEn |-> (padOe[SPI_LO +: SPI_W] == spiOe &&
               (padOut[SPI_LO +: SPI_W] & spiOe) == (spiOut & spiOe)));

  assert_tx_output_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sciTxEn && !(spiEn && TX_PIN >= SPI_LO && TX_PIN < SPI_LO + SPI_W))
      |-> (padOe[TX_PIN] && padOut[TX_PIN] == sciTxOut));

  assert_rx_input_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sciRxEn && !(spiEn && RX_PIN >= SPI_LO && RX_PIN < SPI_LO + SPI_W)
             && !(sciTxEn && TX_PIN == RX_PIN))
      |-> !padOe[RX_PIN]);

  assert_sync_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 2'd2 && busAddr == 2'd1) |-> busRdata == $past(padIn, 2));

  assert_drive_inputs_R11: assert property (@(posedge clk) disable iff (!rstN)
    (padReduced & ~padOe) == '0);
endmodule

bind pinmux_port pinmux_port_chk #(
  .WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES), .RX_PIN(RX_PIN),
  .TX_PIN(TX_PIN), .SPI_LO(SPI_LO), .SPI_W(SPI_W)
) chk_i (.*);

// File: tb/pinmux_port_tb_top.sv
module pinmux_port_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWe = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'h00;
  logic [7:0] busRdata;
  logic       spiEn = 1'b0;
  logic [3:0] spiOe = 4'h0;
  logic [3:0] spiOut = 4'h0;
  logic       sciTxEn = 1'b0;
  logic       sciTxOut = 1'b0;
  logic       sciRxEn = 1'b0;
  logic [7:0] padIn = 8'h00;
  logic [7:0] padOut, padOe, padReduced;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  pinmux_port dut_i (.*);

  typedef struct packed {
    logic       vSpiEn;
    logic [3:0] vSpiOe;
    logic [3:0] vSpiOut;
    logic       vTxEn;
    logic       vTxOut;
    logic       vRxEn;
    logic [7:0] vDir;
    logic [7:0] vData;
    logic [7:0] vDrv;
    logic [7:0] expOe;
    logic [7:0] expOut;
    logic [7:0] expRed;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'hF0, 8'hA5, 8'h3C, 8'hF0, 8'hA0, 8'h30}, // R2 R11
    '{1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b1, 8'hFF, 8'hFF, 8'hFF, 8'hFE, 8'hFE, 8'hFE}, // R6
    '{1'b0, 4'h0, 4'h0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hFF, 8'h02, 8'h02, 8'h00, 8'h02}, // R5 R11
    '{1'b1, 4'h5, 4'hF, 1'b0, 1'b0, 1'b0, 8'hF0, 8'h00, 8'hF0, 8'h50, 8'h50, 8'h50}, // R4
    '{1'b1, 4'hA, 4'h2, 1'b1, 1'b1, 1'b1, 8'h0F, 8'h0C, 8'hFF, 8'hAE, 8'h2E, 8'hAE}, // R4 R5 R6
    '{1'b0, 4'h0, 4'h0, 1'b0, 1'b0, 1'b0, 8'h0F, 8'h0C, 8'h00, 8'h0F, 8'h0C, 8'h00}  // R7
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdata;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    logic [7:0] rd;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 padOe in reset", padOe, 8'h00);
    check("R1 padReduced in reset", padReduced, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    busRead(2'd2, rd); check("R1 dir reset", rd, 8'h00);
    busRead(2'd3, rd); check("R1 drive reset", rd, 8'h00);
    busRead(2'd0, rd); check("R1 data reset", rd, 8'h00);

    // table walk: override resolution
    for (int i = 0; i < NVEC; i++) begin
      spiEn = VECS[i].vSpiEn; spiOe = VECS[i].vSpiOe; spiOut = VECS[i].vSpiOut;
      sciTxEn = VECS[i].vTxEn; sciTxOut = VECS[i].vTxOut; sciRxEn = VECS[i].vRxEn;
      busWrite(2'd2, VECS[i].vDir);
      busWrite(2'd0, VECS[i].vData);
      busWrite(2'd3, VECS[i].vDrv);
      @(negedge clk);
      check($sformatf("R2/R4-R7 vec%0d padOe", i), padOe, VECS[i].expOe);
      check($sformatf("R2/R4-R7 vec%0d padOut", i), padOut & VECS[i].expOe, VECS[i].expOut);
      check($sformatf("R11 vec%0d padReduced", i), padReduced, VECS[i].expRed);
    end

    // R7: receive enable drops, pin 0 returns to its direction bit
    sciRxEn = 1'b1; #1;
    check("R7 rx holds pin0 input", padOe, 8'h0E);
    sciRxEn = 1'b0; #1;
    check("R7 rx released", padOe, 8'h0F);

    // R3: readback
    busWrite(2'd2, 8'h5A);
    busRead(2'd2, rd); check("R3 dir readback", rd, 8'h5A);
    busWrite(2'd3, 8'hC3);
    busRead(2'd3, rd); check("R3 drive readback", rd, 8'hC3);

    // R10: write to the input view is ignored
    busWrite(2'd2, 8'hFF);
    busWrite(2'd0, 8'h3C);
    busWrite(2'd1, 8'hFF);
    busRead(2'd0, rd); check("R10 data unchanged", rd, 8'h3C);
    busRead(2'd2, rd); check("R10 dir unchanged", rd, 8'hFF);
    busRead(2'd3, rd); check("R10 drive unchanged", rd, 8'hC3);
    check("R10 padOut unchanged", padOut, 8'h3C);

    // R8: two-edge synchronizer latency
    busWrite(2'd2, 8'h00);
    padIn = 8'h00;
    repeat (3) @(negedge clk);
    busAddr = 2'd1;
    padIn = 8'h96;
    @(negedge clk);
    check("R8 not visible after one edge", busRdata, 8'h00);
    @(negedge clk);
    check("R8 visible after two edges", busRdata, 8'h96);

    // R9: mixed data read
    busWrite(2'd2, 8'hF0);
    busWrite(2'd0, 8'hA5);
    padIn = 8'h3C;
    repeat (3) @(negedge clk);
    busRead(2'd0, rd); check("R9 mixed data read", rd, 8'hAC);
    busRead(2'd1, rd); check("R9 input view", rd, 8'h3C);

    finishRun();
  end
endmodule